// File: doc/BRIEF.md
# Accumulator Machine Hardwired Control Sequencer

This block is the hardwired control unit of a small accumulator machine, together with the datapath it steers. Words are 16 bits and addresses are 12 bits. An eight-position one-hot ring counter marks the timing step. A small opcode decoder combines the current step with the opcode held in the instruction register. From these it produces the bus driver select, the bus load select, a memory read strobe, an ALU add select and a counter clear.

The datapath has one shared 16-bit bus. Five registers sit on it: address latch, program counter, data buffer, accumulator and instruction register. A word-wide internal memory model also drives it. The memory is filled through a simple write port. A ready input lets a slow memory stretch either read step. The sequencer implements instruction fetch, the Load instruction and the Add instruction. Every other opcode is retired right after decode without touching any register.

The control outputs and register contents come out as ports, so each step of each instruction can be watched from outside.

Top module: `acc_ctrl_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the step output becomes 8'h01 (step T0), and `pc_q`, `ac_q`, `ir_q`, `mar_q` and `mbr_q` all become zero.
- R2: Exactly one bit of `step` is set at all times. Bit k marks step Tk. Unless a hold (R4) or a clear (R9) applies, the set bit moves up one position per cycle, and T7 wraps to T0.
- R3: Fetch takes three steps, using select codes MAR=1, PC=2, MBR=3, AC=4, IR=7 and 0=none/memory. At T0, `wr_sel`=1 and `rd_sel`=2, so the address latch takes the PC. At T1, `wr_sel`=3, `rd_sel`=0 and `mem_rd`=1, so the data buffer takes the memory word and the PC increments by one when the step completes. At T2, `wr_sel`=7 and `rd_sel`=3, so the instruction register takes the data buffer.
- R4: While `mem_rd`=1 and `mem_ready`=0, the step, the program counter and every register stay unchanged at the next edge.
- R5: At T3 (decode), `wr_sel`=0, `rd_sel`=0, and `mem_rd`, `alu_add` and `cnt_clr` are all 0.
- R6: For opcode `ir_q[15:12]` of 4'h1 (Load) or 4'h3 (Add), the steps run as follows. T4: `wr_sel`=1 and `rd_sel`=7, loading the address field. T5: a memory read, as at T1 but without a PC increment. T6: `wr_sel`=4 and `rd_sel`=3, with `alu_add`=1 for Add and 0 for Load. T7: `cnt_clr`=1 only.
- R7: At the end of T6, Add leaves `ac_q` = (old `ac_q` + `mbr_q`) mod 2^16, and Load leaves `ac_q` = `mbr_q`.
- R8: For any other opcode, T4 asserts only `cnt_clr` and no register changes.
- R9: When `cnt_clr` is 1, the next step is T0.
- R10: `bus` carries the selected driver. `rd_sel`=2 gives `{4'h0,pc_q}`, 3 gives `mbr_q`, 7 gives `{4'h0,ir_q[11:0]}`, and 0 gives the memory word at `mar_q` while `mem_rd`=1, or zero otherwise.
- R11: A rising edge with `prog_we`=1 writes `prog_data` to memory word `prog_addr` mod MEM_WORDS (default 256). This works in reset and in run alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_ready | input | 1 | Memory read data valid; low stretches a read step |
| prog_we | input | 1 | Memory model write enable |
| prog_addr | input | 12 | Memory model write address |
| prog_data | input | 16 | Memory model write data |
| step | output | 8 | One-hot timing step, bit k = Tk |
| wr_sel | output | 3 | Code of the register loaded from the bus |
| rd_sel | output | 3 | Code of the bus driver |
| mem_rd | output | 1 | Memory read strobe |
| alu_add | output | 1 | ALU adds when high, passes the bus through when low |
| cnt_clr | output | 1 | Step counter clear |
| bus | output | 16 | Shared datapath bus |
| pc_q | output | 12 | Program counter |
| mar_q | output | 12 | Memory address latch |
| mbr_q | output | 16 | Memory data buffer |
| ir_q | output | 16 | Instruction register |
| ac_q | output | 16 | Accumulator |

## Verification
The control selects, the strobes and the bus are combinational from the current step. They are therefore checked in the same cycle the step is entered. Register results and the next step land one rising edge after the step that causes them, or after the last waited cycle of a stretched read. The bench keeps a step-level model that it advances once per rising edge, using the inputs it drove for that edge. It compares every output at the following falling edge. Random `mem_ready` stalls and run-time memory writes move those due cycles around, and the model follows them rather than assuming fixed instruction lengths.

// File: rtl/acc_seq_pkg.sv
// Package: shared widths, bus select codes and opcodes for the sequencer.
// Assumes a single shared bus with 3-bit driver and load select codes.
package acc_seq_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 12;
    localparam int OP_W   = 4;
    localparam int SEL_W  = 3;
    localparam int STEPS  = 8;

    localparam logic [SEL_W-1:0] SEL_NONE = 3'd0;
    localparam logic [SEL_W-1:0] SEL_MAR  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_PC   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_MBR  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_AC   = 3'd4;
    localparam logic [SEL_W-1:0] SEL_IR   = 3'd7;

    localparam logic [OP_W-1:0] OP_LOAD = 4'h1;
    localparam logic [OP_W-1:0] OP_ADD  = 4'h3;
endpackage

// File: rtl/acc_ring.sv
// Module: one-hot ring counter of D flip-flops giving the timing steps.
// Assumes clr has priority over hold; reset parks the ring at bit 0.
module acc_ring #(
    parameter int STEPS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             clr,
    output logic [STEPS-1:0] step
);
    for (genvar i = 0; i < STEPS; i++) begin : g_ff
        localparam int PREV = (i + STEPS - 1) % STEPS;
        // One stage: restart, keep, or take the previous stage's bit.
        always_ff @(posedge clk) begin
            if (!rst_n)      step[i] <= (i == 0);
            else if (clr)    step[i] <= (i == 0);
            else if (!hold)  step[i] <= step[PREV];
        end
    end

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(step) == 1);
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> step == STEPS'(1));
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr) |=> $stable(step));
endmodule

// File: rtl/acc_decode.sv
// Module: partial opcode decoder; combines step and opcode into control lines.
// Assumes step is one-hot with bit k = Tk; only Load and Add run past T4.
module acc_decode
    import acc_seq_pkg::*;
#(
    parameter int STEPS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STEPS-1:0] step,
    input  logic [OP_W-1:0]  opcode,
    output logic [SEL_W-1:0] wr_sel,
    output logic [SEL_W-1:0] rd_sel,
    output logic             mem_rd,
    output logic             alu_add,
    output logic             cnt_clr,
    output logic             pc_inc
);
    logic is_load, is_add, is_mem_op;

    // Opcode recognition for the two implemented memory instructions.
    always_comb begin
        is_load   = (opcode == OP_LOAD);
        is_add    = (opcode == OP_ADD);
        is_mem_op = is_load || is_add;
    end

    // Control lines for each step.
    always_comb begin
        wr_sel  = SEL_NONE;
        rd_sel  = SEL_NONE;
        mem_rd  = 1'b0;
        alu_add = 1'b0;
        cnt_clr = 1'b0;
        pc_inc  = step[1];
        if (step[0]) begin
            wr_sel = SEL_MAR;
            rd_sel = SEL_PC;
        end
        if (step[1] || (step[5] && is_mem_op)) begin
            wr_sel = SEL_MBR;
            mem_rd = 1'b1;
        end
        if (step[2]) begin
            wr_sel = SEL_IR;
            rd_sel = SEL_MBR;
        end
        if (step[4]) begin
            if (is_mem_op) begin
                wr_sel = SEL_MAR;
                rd_sel = SEL_IR;
            end else begin
                cnt_clr = 1'b1;
            end
        end
        if (step[6] && is_mem_op) begin
            wr_sel  = SEL_AC;
            rd_sel  = SEL_MBR;
            alu_add = is_add;
        end
        if (step[7]) cnt_clr = 1'b1;
    end

    assert_rd_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (wr_sel == SEL_MBR && rd_sel == SEL_NONE));
    assert_decode_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step[3] |-> (wr_sel == SEL_NONE && !mem_rd && !cnt_clr));
    assert_add_only_ac_R6: assert property (@(posedge clk) disable iff (!rst_n)
        alu_add |-> (wr_sel == SEL_AC && step[6]));
endmodule

// File: rtl/acc_datapath.sv
// Module: shared-bus datapath with registers and a word memory model.
// Assumes MEM_WORDS is a power of two no larger than 2**ADDR_W; memory is not reset.
module acc_datapath
    import acc_seq_pkg::*;
#(
    parameter int MEM_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic              mem_rd,
    input  logic              alu_add,
    input  logic              pc_inc,
    input  logic              hold,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [WORD_W-1:0] prog_data,
    output logic [WORD_W-1:0] bus,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] mar_q,
    output logic [WORD_W-1:0] mbr_q,
    output logic [WORD_W-1:0] ir_q,
    output logic [WORD_W-1:0] ac_q
);
    localparam int IDX_W = $clog2(MEM_WORDS);

    logic [WORD_W-1:0] mem [MEM_WORDS];
    logic [WORD_W-1:0] mem_word;
    logic [WORD_W-1:0] alu_out;
    logic              xfer;

    // Memory model write port.
    always_ff @(posedge clk) begin
        if (prog_we) mem[prog_addr[IDX_W-1:0]] <= prog_data;
    end

    // Bus driver selection and ALU.
    always_comb begin
        mem_word = mem[mar_q[IDX_W-1:0]];
        case (rd_sel)
            SEL_MAR: bus = {{(WORD_W-ADDR_W){1'b0}}, mar_q};
            SEL_PC:  bus = {{(WORD_W-ADDR_W){1'b0}}, pc_q};
            SEL_MBR: bus = mbr_q;
            SEL_AC:  bus = ac_q;
            SEL_IR:  bus = {{(WORD_W-ADDR_W){1'b0}}, ir_q[ADDR_W-1:0]};
            default: bus = mem_rd ? mem_word : '0;
        endcase
        alu_out = alu_add ? ac_q + bus : bus;
        xfer    = !hold;
    end

    // Register loads from the bus and PC increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            mar_q <= '0;
            mbr_q <= '0;
            ir_q  <= '0;
            ac_q  <= '0;
        end else if (xfer) begin
            if (pc_inc)             pc_q  <= pc_q + 1'b1;
            if (wr_sel == SEL_MAR)  mar_q <= bus[ADDR_W-1:0];
            if (wr_sel == SEL_MBR)  mbr_q <= bus;
            if (wr_sel == SEL_IR)   ir_q  <= bus;
            if (wr_sel == SEL_AC)   ac_q  <= alu_out;
        end
    end

    assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc && !hold) |=> pc_q == $past(pc_q) + 1'b1);
    assert_add_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel == SEL_AC && alu_add && !hold) |=> ac_q == WORD_W'($past(ac_q) + $past(mbr_q)));
    assert_wait_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(pc_q) && $stable(mbr_q) && $stable(ac_q)));
endmodule

// File: rtl/acc_ctrl_seq.sv
// Module: top of the hardwired control sequencer with its datapath.
// Assumes mem_ready only matters during a read step; reset is synchronous.
module acc_ctrl_seq
    import acc_seq_pkg::*;
#(
    parameter int MEM_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_ready,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [WORD_W-1:0] prog_data,
    output logic [STEPS-1:0]  step,
    output logic [SEL_W-1:0]  wr_sel,
    output logic [SEL_W-1:0]  rd_sel,
    output logic              mem_rd,
    output logic              alu_add,
    output logic              cnt_clr,
    output logic [WORD_W-1:0] bus,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] mar_q,
    output logic [WORD_W-1:0] mbr_q,
    output logic [WORD_W-1:0] ir_q,
    output logic [WORD_W-1:0] ac_q
);
    logic hold;
    logic pc_inc;

    // A read step waits for the memory.
    always_comb hold = mem_rd && !mem_ready;

    acc_ring #(.STEPS(STEPS)) u_ring (
        .clk(clk), .rst_n(rst_n), .hold(hold), .clr(cnt_clr), .step(step)
    );

    acc_decode #(.STEPS(STEPS)) u_dec (
        .clk(clk), .rst_n(rst_n), .step(step), .opcode(ir_q[WORD_W-1 -: OP_W]),
        .wr_sel(wr_sel), .rd_sel(rd_sel), .mem_rd(mem_rd), .alu_add(alu_add),
        .cnt_clr(cnt_clr), .pc_inc(pc_inc)
    );

    acc_datapath #(.MEM_WORDS(MEM_WORDS)) u_dp (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .rd_sel(rd_sel),
        .mem_rd(mem_rd), .alu_add(alu_add), .pc_inc(pc_inc), .hold(hold),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .bus(bus), .pc_q(pc_q), .mar_q(mar_q), .mbr_q(mbr_q), .ir_q(ir_q), .ac_q(ac_q)
    );
endmodule

// File: tb/acc_ctrl_seq_test.sv
module acc_ctrl_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYCLES = 4000;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_ready = 1'b1;
    logic        prog_we = 1'b0;
    logic [11:0] prog_addr = '0;
    logic [15:0] prog_data = '0;
    logic [7:0]  step;
    logic [2:0]  wr_sel, rd_sel;
    logic        mem_rd, alu_add, cnt_clr;
    logic [15:0] bus, mbr_q, ir_q, ac_q;
    logic [11:0] pc_q, mar_q;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [15:0] m [256];

    acc_ctrl_seq uut (
        .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready), .prog_we(prog_we),
        .prog_addr(prog_addr), .prog_data(prog_data), .step(step), .wr_sel(wr_sel),
        .rd_sel(rd_sel), .mem_rd(mem_rd), .alu_add(alu_add), .cnt_clr(cnt_clr),
        .bus(bus), .pc_q(pc_q), .mar_q(mar_q), .mbr_q(mbr_q), .ir_q(ir_q), .ac_q(ac_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Expected control lines per step, from R3, R5, R6, R8.
    task automatic exp_ctrl(input int s, input logic [3:0] op,
                            output logic [2:0] w, output logic [2:0] r,
                            output logic mr, output logic al, output logic cl);
        bit memop = (op == 4'h1) || (op == 4'h3);
        w = 0; r = 0; mr = 0; al = 0; cl = 0;
        case (s)
            0: begin w = 1; r = 2; end
            1: begin w = 3; mr = 1; end
            2: begin w = 7; r = 3; end
            4: if (memop) begin w = 1; r = 7; end else cl = 1;
            5: if (memop) begin w = 3; mr = 1; end
            6: if (memop) begin w = 4; r = 3; al = (op == 4'h3); end
            7: cl = 1;
            default: ;
        endcase
    endtask

    function automatic logic [15:0] exp_bus(input logic [2:0] r, input logic mr,
            input logic [11:0] pc, input logic [11:0] mar, input logic [15:0] mbr,
            input logic [15:0] ir);
        case (r)
            3'd2: return {4'h0, pc};
            3'd3: return mbr;
            3'd7: return {4'h0, ir[11:0]};
            default: return mr ? m[mar[7:0]] : 16'h0;
        endcase
    endfunction

    initial begin
        int s;
        logic [11:0] e_pc, e_mar;
        logic [15:0] e_mbr, e_ir, e_ac, eb;
        logic [2:0]  ew, er;
        logic        em, ea, ec, hold, was_hold;
        logic [7:0]  prev_step;
        int          ns;
        logic [11:0] n_pc, n_mar;
        logic [15:0] n_mbr, n_ir, n_ac;
        logic        wr_now;
        logic [7:0]  wr_idx;
        logic [15:0] wr_dat;

        void'($urandom(32'd2024));
        // Program: directed start, random rest (R11 load during reset).
        for (int a = 0; a < 256; a++) m[a] = 16'($urandom);
        m[0] = 16'h1081;   // Load [0x081]
        m[1] = 16'h3082;   // Add  [0x082]
        m[2] = 16'h3083;   // Add  [0x083]
        m[3] = 16'h7000;   // other opcode
        m[4] = 16'h1B81;   // Load [0xB81] aliases word 0x81
        m[5] = 16'h3F82;   // Add aliases 0x82
        m[8'h81] = 16'h0003;
        m[8'h82] = 16'hFFFF;  // wraps the sum (R7)
        m[8'h83] = 16'h1234;
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            prog_we = 1'b1;
            prog_addr = (a % 2 == 0) ? 12'(a) : 12'(a) | 12'h300; // R11 aliasing
            prog_data = m[a];
        end
        @(negedge clk);
        prog_we = 1'b0;
        @(negedge clk);
        chk("R1 step", {8'h0, step}, 16'h0001);
        chk("R1 pc", {4'h0, pc_q}, 16'h0);
        chk("R1 ac", ac_q, 16'h0);
        chk("R1 ir", ir_q, 16'h0);
        chk("R1 mar", {4'h0, mar_q}, 16'h0);
        chk("R1 mbr", mbr_q, 16'h0);
        rst_n = 1'b1;
        s = 0; e_pc = 0; e_mar = 0; e_mbr = 0; e_ir = 0; e_ac = 0;
        was_hold = 1'b0; prev_step = 8'h01;

        for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
            if (cyc != 0) @(negedge clk);
            exp_ctrl(s, e_ir[15:12], ew, er, em, ea, ec);
            eb = exp_bus(er, em, e_pc, e_mar, e_mbr, e_ir);
            chk("R2 R9 step", {8'h0, step}, {8'h0, 8'(1 << s)});
            if (was_hold) chk("R4 step held", {8'h0, step}, {8'h0, prev_step});
            chk(s == 3 ? "R5 wr_sel" : "R3 R6 wr_sel", {13'h0, wr_sel}, {13'h0, ew});
            chk(s == 3 ? "R5 rd_sel" : "R3 R6 rd_sel", {13'h0, rd_sel}, {13'h0, er});
            chk("R3 mem_rd", {15'h0, mem_rd}, {15'h0, em});
            chk("R6 alu_add", {15'h0, alu_add}, {15'h0, ea});
            chk(s == 4 ? "R8 cnt_clr" : "R9 cnt_clr", {15'h0, cnt_clr}, {15'h0, ec});
            chk("R10 R11 bus", bus, eb);
            chk("R3 pc", {4'h0, pc_q}, {4'h0, e_pc});
            chk("R6 mar", {4'h0, mar_q}, {4'h0, e_mar});
            chk("R3 mbr", mbr_q, e_mbr);
            chk("R3 ir", ir_q, e_ir);
            chk("R7 R8 ac", ac_q, e_ac);

            // Drive this edge's inputs.
            mem_ready = (cyc < 60) ? 1'b1 : ($urandom % 10 < 7);
            wr_now = (cyc > 60) && ($urandom % 40 == 0);
            prog_we = wr_now;
            prog_addr = 12'($urandom);
            prog_data = 16'($urandom);
            wr_idx = prog_addr[7:0];
            wr_dat = prog_data;

            // Next expected state from R2-R9.
            hold = em && !mem_ready;
            n_pc = e_pc; n_mar = e_mar; n_mbr = e_mbr; n_ir = e_ir; n_ac = e_ac;
            ns = s;
            if (!hold) begin
                if (s == 1) n_pc = e_pc + 12'd1;
                case (ew)
                    3'd1: n_mar = eb[11:0];
                    3'd3: n_mbr = eb;
                    3'd7: n_ir = eb;
                    3'd4: n_ac = ea ? 16'(e_ac + eb) : eb;
                    default: ;
                endcase
                ns = ec ? 0 : (s + 1) % 8;
            end
            prev_step = step;
            was_hold = hold;
            @(posedge clk);
            if (wr_now) m[wr_idx] = wr_dat;
            s = ns; e_pc = n_pc; e_mar = n_mar; e_mbr = n_mbr; e_ir = n_ir; e_ac = n_ac;
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule